// File: doc/BRIEF.md
# Macroblock Decoder Host Register Interface

This block is the register front end of a macroblock decoder coprocessor. A host bus reaches it through a small window of 32-bit word registers. The data port feeds command and parameter words into an input queue, from which the decoder core draws them, and hands decoded words back from an output queue. A second register reports the live queue flags and the request state when read. When written, it takes DMA enables and a soft-reset request.

A DMA engine has its own strobes that push into the input queue and pop from the output queue with the same effect as host accesses to the data port. The block drives one request line for each DMA direction. The decoding arithmetic is not part of this block. The core side has a pop port on the input queue, and a test-side load port fills the output queue.

Top module: `dec_hostif`

## Requirements
- R1: After the synchronous reset, a status read returns 0x80000000 (bit 31 output-empty set, every other field, including busy at bit 29, depth at 26:25, signed at 24, bit15 value at 23, block at 18:16 and remaining count at 15:0, zero), both DMA request outputs are low and the read strobes are low.
- R2: A word write to offset 0x0 pushes the write data into the input queue, and the core pop port returns pushed words in push order, one cycle after each pop strobe with `cmd_valid` high.
- R3: The input queue holds DEPTH (256) words. A push while it is full is dropped, and status bit 30 (input full) stays 1 until a word leaves.
- R4: A word read from offset 0x0 pops the output queue and returns its words in load order.
- R5: A read from offset 0x0 while the output queue is empty returns 0xFFFFFFFF and leaves the queue unchanged.
- R6: A read from any offset other than 0x0 and 0x4 returns 0xFFFFFFFF. A write to such an offset changes nothing.
- R7: A word write to offset 0x4 copies control bit 30 to status bit 28 and `dreq_in`, and control bit 29 to status bit 27 and `dreq_out`, one cycle later.
- R8: Control bit 31 set empties both queues and clears the status word. The enables of the same write are then applied, so control 0xC0000000 leaves status 0x90000000.
- R9: Status bit 31 (output empty) and bit 30 (input full) follow every push, pop and soft reset, and a status read issued the cycle after such an event shows the new value.
- R10: `dma_in_wr` pushes `dma_in_data` into the input queue. `dma_out_rd` pops the output queue onto `dma_out_data` with `dma_out_valid` high one cycle later, and returns 0xFFFFFFFF when the queue is empty.
- R11: A DMA strobe in a cycle where `host_valid` is high is dropped: no push, no pop, and no `dma_out_valid`.
- R12: A host access with `host_be` other than 4'hF raises `host_err` for one cycle and has no other effect. A read of that kind returns 0xFFFFFFFF.
- R13: A host read raises `host_rvalid` with its data exactly one cycle after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register offset within the window |
| host_be | input | 4 | Byte enables; only 4'hF is a legal access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_rvalid | output | 1 | Read data valid |
| host_err | output | 1 | Non-word access flagged |
| dma_in_wr | input | 1 | DMA push strobe |
| dma_in_data | input | 32 | DMA push data |
| dma_out_rd | input | 1 | DMA pop strobe |
| dma_out_data | output | 32 | DMA pop data |
| dma_out_valid | output | 1 | DMA pop data valid |
| dreq_in | output | 1 | Input-direction DMA request |
| dreq_out | output | 1 | Output-direction DMA request |
| cmd_rd | input | 1 | Core pop strobe on the input queue |
| cmd_data | output | 32 | Word popped for the core |
| cmd_valid | output | 1 | Core pop data valid |
| tload_valid | input | 1 | Test-side push into the output queue |
| tload_data | input | 32 | Test-side push data |

## Verification
The bench fills the input queue one word past its depth. A design that overwrote the oldest entry or wrapped its count would show the wrong final word or a cleared full bit. It reads the data port with the output queue empty, where a design that popped anyway would return stale data and lose the next real word. It issues a soft reset together with an enable and expects the enable to survive the reset, and it drives host and DMA strobes in the same cycle to catch a design that lets the DMA access through or merges both. Unmapped writes and partial-width accesses must leave the status word and the queue contents unchanged.

// File: rtl/dec_hostif_pkg.sv
package dec_hostif_pkg;
  localparam int WORD_W = 32;
  localparam int OFS_W  = 4;

  localparam logic [OFS_W-1:0] OFS_DATA = 4'h0;
  localparam logic [OFS_W-1:0] OFS_CSR  = 4'h4;

  // control word bits
  localparam int CT_SRST   = 31;
  localparam int CT_EN_IN  = 30;
  localparam int CT_EN_OUT = 29;

  // decoder-owned status fields (driven by the core, zero here)
  typedef struct packed {
    logic        busy;
    logic [1:0]  depth;     // 0:4b 1:8b 2:24b 3:15b
    logic        sgn;
    logic        b15;
    logic [2:0]  blk;
    logic [15:0] remain;
  } dec_state_t;

  function automatic logic [WORD_W-1:0] pack_status(
    input logic out_empty, input logic in_full,
    input logic rq_in, input logic rq_out, input dec_state_t st);
    return {out_empty, in_full, st.busy, rq_in, rq_out, st.depth,
            st.sgn, st.b15, 4'b0000, st.blk, st.remain};
  endfunction
endpackage

// File: rtl/dec_word_fifo.sv
module dec_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_hit,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ok = wr_en & ~full  & ~clr;
  assign rd_ok = rd_en & ~empty & ~clr;

  always_comb begin
    cnt_n = cnt;
    if (wr_ok && !rd_ok) cnt_n = cnt + 1'b1;
    if (rd_ok && !wr_ok) cnt_n = cnt - 1'b1;
  end

  // storage: no reset, single write and registered read for RAM inference
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      empty  <= 1'b1;
      full   <= 1'b0;
      rd_hit <= 1'b0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      cnt    <= cnt_n;
      empty  <= (cnt_n == '0);
      full   <= (cnt_n == CW'(DEPTH));
      rd_hit <= rd_ok;
    end
  end

  // R3: a push into a full queue is lost and the queue stays full
  p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !clr) |=> (full && $stable(wptr)));

  // R5: popping an empty queue changes nothing and yields no data
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !clr) |=> (empty && !rd_hit && $stable(rptr)));
endmodule

// File: rtl/dec_access_arb.sv
module dec_access_arb
  import dec_hostif_pkg::*;
(
  input  logic             host_valid,
  input  logic             host_write,
  input  logic [OFS_W-1:0] host_addr,
  input  logic [3:0]       host_be,
  input  logic             dma_in_wr,
  input  logic             dma_out_rd,
  output logic             push_host,
  output logic             push_dma,
  output logic             pop_host,
  output logic             pop_dma,
  output logic             csr_wr,
  output logic             csr_rd,
  output logic             ones_rd,
  output logic             size_err
);
  logic word_ok;
  logic hit_data, hit_csr;

  assign word_ok  = host_valid & (&host_be);
  assign size_err = host_valid & ~(&host_be);
  assign hit_data = (host_addr == OFS_DATA);
  assign hit_csr  = (host_addr == OFS_CSR);

  assign push_host = word_ok &  host_write & hit_data;
  assign pop_host  = word_ok & ~host_write & hit_data;
  assign csr_wr    = word_ok &  host_write & hit_csr;
  assign csr_rd    = word_ok & ~host_write & hit_csr;
  // unmapped reads and rejected-size reads both answer all ones
  assign ones_rd   = host_valid & ~host_write & ~((&host_be) & (hit_data | hit_csr));

  // host owns the cycle whenever it presents any request
  assign push_dma  = ~host_valid & dma_in_wr;
  assign pop_dma   = ~host_valid & dma_out_rd;
endmodule

// File: rtl/dec_hostif.sv
module dec_hostif
  import dec_hostif_pkg::*;
#(
  parameter int IN_DEPTH  = 256,
  parameter int OUT_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [3:0]        host_be,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_err,
  input  logic              dma_in_wr,
  input  logic [WORD_W-1:0] dma_in_data,
  input  logic              dma_out_rd,
  output logic [WORD_W-1:0] dma_out_data,
  output logic              dma_out_valid,
  output logic              dreq_in,
  output logic              dreq_out,
  input  logic              cmd_rd,
  output logic [WORD_W-1:0] cmd_data,
  output logic              cmd_valid,
  input  logic              tload_valid,
  input  logic [WORD_W-1:0] tload_data
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic push_host, push_dma, pop_host, pop_dma;
  logic csr_wr, csr_rd, ones_rd, size_err;
  logic srst;
  logic in_empty, in_full, out_empty, out_full;
  logic out_hit;
  logic [WORD_W-1:0] out_q;
  logic [WORD_W-1:0] in_wdata;
  logic in_empty_unused, out_full_unused;

  logic [WORD_W-1:0] hrd_q;
  logic              host_from_q;
  dec_state_t        dstate;

  dec_access_arb u_arb (
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_be    (host_be),
    .dma_in_wr  (dma_in_wr),
    .dma_out_rd (dma_out_rd),
    .push_host  (push_host),
    .push_dma   (push_dma),
    .pop_host   (pop_host),
    .pop_dma    (pop_dma),
    .csr_wr     (csr_wr),
    .csr_rd     (csr_rd),
    .ones_rd    (ones_rd),
    .size_err   (size_err)
  );

  assign srst     = csr_wr & host_wdata[CT_SRST];
  assign in_wdata = push_host ? host_wdata : dma_in_data;

  dec_word_fifo #(.DW(WORD_W), .DEPTH(IN_DEPTH)) u_in_q (
    .clk     (clk),
    .rst     (rst),
    .clr     (srst),
    .wr_en   (push_host | push_dma),
    .wr_data (in_wdata),
    .rd_en   (cmd_rd),
    .rd_data (cmd_data),
    .rd_hit  (cmd_valid),
    .empty   (in_empty),
    .full    (in_full)
  );

  dec_word_fifo #(.DW(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk     (clk),
    .rst     (rst),
    .clr     (srst),
    .wr_en   (tload_valid),
    .wr_data (tload_data),
    .rd_en   (pop_host | pop_dma),
    .rd_data (out_q),
    .rd_hit  (out_hit),
    .empty   (out_empty),
    .full    (out_full)
  );

  assign in_empty_unused = in_empty;
  assign out_full_unused = out_full;

  // control / request state
  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_in  <= 1'b0;
      dreq_out <= 1'b0;
      dstate   <= '0;
    end else if (csr_wr) begin
      if (srst) dstate <= '0;
      // enables land after any reset carried by the same word
      dreq_in  <= host_wdata[CT_EN_IN];
      dreq_out <= host_wdata[CT_EN_OUT];
    end
  end

  // host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      hrd_q         <= '0;
      host_from_q   <= 1'b0;
      host_rvalid   <= 1'b0;
      host_err      <= 1'b0;
      dma_out_valid <= 1'b0;
    end else begin
      host_rvalid   <= host_valid & ~host_write;
      host_err      <= size_err;
      host_from_q   <= pop_host;
      dma_out_valid <= pop_dma;
      if (csr_rd)
        hrd_q <= pack_status(out_empty, in_full, dreq_in, dreq_out, dstate);
      else if (ones_rd)
        hrd_q <= ALL_ONES;
    end
  end

  assign host_rdata   = host_from_q ? (out_hit ? out_q : ALL_ONES) : hrd_q;
  assign dma_out_data = out_hit ? out_q : ALL_ONES;

  // R7: request lines follow the enables of a control write
  p_ctrl_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_write && (&host_be) && host_addr == OFS_CSR)
    |=> (dreq_in == $past(host_wdata[CT_EN_IN]) && dreq_out == $past(host_wdata[CT_EN_OUT])));

  // R8: soft reset leaves the output queue empty
  p_srst_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_write && (&host_be) && host_addr == OFS_CSR && host_wdata[CT_SRST])
    |=> (out_empty && !out_hit));

  // R11: a DMA pop that collides with a host access is not served
  p_host_first_r11: assert property (@(posedge clk) disable iff (rst)
    (host_valid && dma_out_rd) |=> !dma_out_valid);

  // R12: partial-width access flagged next cycle
  p_size_err_r12: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_be != 4'hF) |=> host_err);

  // R13: one-cycle read latency
  p_read_lat_r13: assert property (@(posedge clk) disable iff (rst)
    (host_valid && !host_write) |=> host_rvalid);
endmodule

// File: tb/tb_dec_hostif.sv
module tb_dec_hostif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [3:0]  host_addr = '0, host_be = 4'hF;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid, host_err;
  logic        dma_in_wr = 1'b0, dma_out_rd = 1'b0;
  logic [31:0] dma_in_data = '0;
  logic [31:0] dma_out_data;
  logic        dma_out_valid, dreq_in, dreq_out;
  logic        cmd_rd = 1'b0;
  logic [31:0] cmd_data;
  logic        cmd_valid;
  logic        tload_valid = 1'b0;
  logic [31:0] tload_data = '0;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dec_hostif dut (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_err(host_err),
    .dma_in_wr(dma_in_wr), .dma_in_data(dma_in_data),
    .dma_out_rd(dma_out_rd), .dma_out_data(dma_out_data), .dma_out_valid(dma_out_valid),
    .dreq_in(dreq_in), .dreq_out(dreq_out),
    .cmd_rd(cmd_rd), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .tload_valid(tload_valid), .tload_data(tload_data)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [3:0]  ofs;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{8'd1,  1'b0, 4'h4, 32'h0,        32'h8000_0000}, // R1 status after reset
    '{8'd7,  1'b1, 4'h4, 32'h6000_0000, 32'h0},        // R7 both enables
    '{8'd7,  1'b0, 4'h4, 32'h0,        32'h9800_0000},
    '{8'd7,  1'b1, 4'h4, 32'h0000_0000, 32'h0},
    '{8'd7,  1'b0, 4'h4, 32'h0,        32'h8000_0000},
    '{8'd6,  1'b0, 4'h8, 32'h0,        32'hFFFF_FFFF}, // R6 unmapped reads
    '{8'd6,  1'b0, 4'hC, 32'h0,        32'hFFFF_FFFF},
    '{8'd5,  1'b0, 4'h0, 32'h0,        32'hFFFF_FFFF}, // R5 empty pop
    '{8'd6,  1'b1, 4'h8, 32'h1234_5678, 32'h0},        // R6 ignored write
    '{8'd6,  1'b1, 4'hF, 32'h6000_0000, 32'h0},
    '{8'd6,  1'b0, 4'h4, 32'h0,        32'h8000_0000},
    '{8'd9,  1'b1, 4'h0, 32'hAAAA_0001, 32'h0},        // R9 one push
    '{8'd9,  1'b0, 4'h4, 32'h0,        32'h8000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  // each op starts at a negedge and ends at the next, outputs then settled
  task automatic host_op(input logic w, input logic [3:0] a, input logic [3:0] be,
                         input logic [31:0] d);
    host_valid = 1'b1; host_write = w; host_addr = a; host_be = be; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0; host_be = 4'hF;
  endtask

  task automatic cmd_pop();
    cmd_rd = 1'b1;
    @(negedge clk);
    cmd_rd = 1'b0;
  endtask

  task automatic tload(input logic [31:0] d);
    tload_valid = 1'b1; tload_data = d;
    @(negedge clk);
    tload_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    check("R1 dreq_in", {31'b0, dreq_in}, 32'h0);
    check("R1 dreq_out", {31'b0, dreq_out}, 32'h0);
    check("R1 rvalid", {31'b0, host_rvalid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i].wr, VEC[i].ofs, 4'hF, VEC[i].data);
      if (!VEC[i].wr) begin
        total++;
        if (host_rdata !== VEC[i].exp || host_rvalid !== 1'b1) begin
          failed++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VEC[i].req, i,
                   host_rdata, VEC[i].exp);
        end
      end
    end
    // R6: ignored write left no word; R2 only the pushed word is queued
    cmd_pop();
    check("R2 first pop", cmd_data, 32'hAAAA_0001);
    cmd_pop();
    check("R6 no extra word", {31'b0, cmd_valid}, 32'h0);

    // R2: order through the core port
    for (int i = 0; i < 3; i++) host_op(1'b1, 4'h0, 4'hF, 32'hC0DE_0000 + i);
    for (int i = 0; i < 3; i++) begin
      cmd_pop();
      check("R2 order", cmd_data, 32'hC0DE_0000 + i);
      check("R2 valid", {31'b0, cmd_valid}, 32'h1);
    end

    // R3: fill past depth
    for (int i = 0; i < 257; i++) host_op(1'b1, 4'h0, 4'hF, 32'h1000 + i);
    host_op(1'b0, 4'h4, 4'hF, 32'h0);
    check("R3 full status", host_rdata, 32'hC000_0000);
    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) begin
        cmd_pop();
        if (cmd_data !== 32'h1000 + i) bad++;
      end
      check("R3 contents", bad, 0);
      check("R3 last kept", cmd_data, 32'h1000 + 255);
    end
    cmd_pop();
    check("R3 dropped word", {31'b0, cmd_valid}, 32'h0);

    // R4 / R9: output queue via host reads
    for (int i = 0; i < 3; i++) tload(32'hBEEF_0000 + i);
    host_op(1'b0, 4'h4, 4'hF, 32'h0);
    check("R9 not empty", host_rdata, 32'h0000_0000);
    for (int i = 0; i < 3; i++) begin
      host_op(1'b0, 4'h0, 4'hF, 32'h0);
      check("R4 order", host_rdata, 32'hBEEF_0000 + i);
      check("R13 rvalid", {31'b0, host_rvalid}, 32'h1);
    end
    host_op(1'b0, 4'h4, 4'hF, 32'h0);
    check("R9 empty again", host_rdata, 32'h8000_0000);
    host_op(1'b0, 4'h0, 4'hF, 32'h0);
    check("R5 empty read", host_rdata, 32'hFFFF_FFFF);
    tload(32'h5555_AAAA);
    host_op(1'b0, 4'h0, 4'hF, 32'h0);
    check("R5 queue unchanged", host_rdata, 32'h5555_AAAA);

    // R8: reset with enable in same word
    tload(32'h1); tload(32'h2);
    host_op(1'b1, 4'h0, 4'hF, 32'h77);
    host_op(1'b1, 4'h4, 4'hF, 32'hC000_0000);
    check("R8 dreq_in", {31'b0, dreq_in}, 32'h1);
    check("R8 dreq_out", {31'b0, dreq_out}, 32'h0);
    host_op(1'b0, 4'h4, 4'hF, 32'h0);
    check("R8 status", host_rdata, 32'h9000_0000);
    host_op(1'b0, 4'h0, 4'hF, 32'h0);
    check("R8 out cleared", host_rdata, 32'hFFFF_FFFF);
    cmd_pop();
    check("R8 in cleared", {31'b0, cmd_valid}, 32'h0);

    // R10: DMA side
    dma_in_wr = 1'b1; dma_in_data = 32'hD0A0_0001;
    @(negedge clk); dma_in_wr = 1'b0;
    cmd_pop();
    check("R10 dma push", cmd_data, 32'hD0A0_0001);
    tload(32'hD0B0_0002);
    dma_out_rd = 1'b1;
    @(negedge clk); dma_out_rd = 1'b0;
    check("R10 dma pop", dma_out_data, 32'hD0B0_0002);
    check("R10 dma valid", {31'b0, dma_out_valid}, 32'h1);
    dma_out_rd = 1'b1;
    @(negedge clk); dma_out_rd = 1'b0;
    check("R10 dma empty", dma_out_data, 32'hFFFF_FFFF);

    // R11: host wins the cycle
    dma_in_wr = 1'b1; dma_in_data = 32'hBAD0_0000;
    host_op(1'b1, 4'h0, 4'hF, 32'h600D_0000);
    dma_in_wr = 1'b0;
    cmd_pop();
    check("R11 host word", cmd_data, 32'h600D_0000);
    cmd_pop();
    check("R11 dma dropped", {31'b0, cmd_valid}, 32'h0);
    tload(32'h0DD0_0003);
    dma_out_rd = 1'b1;
    host_op(1'b0, 4'h4, 4'hF, 32'h0);
    dma_out_rd = 1'b0;
    check("R11 no dma valid", {31'b0, dma_out_valid}, 32'h0);
    host_op(1'b0, 4'h0, 4'hF, 32'h0);
    check("R11 word kept", host_rdata, 32'h0DD0_0003);

    // R12: partial-width accesses
    host_op(1'b1, 4'h0, 4'h3, 32'h0000_00EE);
    check("R12 err write", {31'b0, host_err}, 32'h1);
    cmd_pop();
    check("R12 no push", {31'b0, cmd_valid}, 32'h0);
    host_op(1'b0, 4'h4, 4'h1, 32'h0);
    check("R12 err read", {31'b0, host_err}, 32'h1);
    check("R12 read ones", host_rdata, 32'hFFFF_FFFF);
    host_op(1'b1, 4'h4, 4'h8, 32'h6000_0000);
    check("R12 ctrl untouched", {30'b0, dreq_in, dreq_out}, 32'h2);
    @(negedge clk);
    check("R12 err pulse", {31'b0, host_err}, 32'h0);

    report();
  end
endmodule